// File: doc/BRIEF.md
# Priority Interrupt Request Controller

This block gathers interrupt requests from a small set of sources, such as general-purpose input pins or peripherals, for an 8-bit processor. Each raw request line passes through a two-stage synchronizer and a rising-edge detector. A detected edge sets a sticky pending bit. Every source is given one of four levels: off, low, medium or high. A source's level is formed from one bit in a level-high register and the bit at the same position in a level-low register.

When the global enable is set, the block picks the enabled pending source with the highest level. It raises a registered interrupt line and presents that source's index as the vector. The vector stays fixed until the processor acknowledges it. The acknowledge clears the pending bit of the served source. When the global enable is clear, pending bits still collect and software finds them by polling the pending register. All registers sit on a simple register bus whose read data is registered.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_o is 0, vec_o is 0, and reads at all four addresses return 0.
- R2: A source's pending bit becomes 1 at the third rising clock edge after its input goes high, through two synchronizer flops and an edge detector. A level held high sets the pending bit only once.
- R3: The register map is as follows. Address 0 is the pending register. Address 1 holds the level-high bits and address 2 holds the level-low bits. Address 3 holds the global enable in bit 0. Source i uses bit i. Bits at and above NUM_SRC (bits 7 to 4 by default), and bits 7 to 1 at address 3, read as 0 and ignore writes. Read data appears one cycle after the address is presented.
- R4: The level of source i is {high[i], low[i]}: 00 is off, 01 is low, 10 is medium and 11 is high. A source that is off still sets its pending bit but never wins arbitration.
- R5: Among pending sources that are not off, the highest level wins. Within one level, the lowest index wins.
- R6: irq_o rises on the clock edge after a qualifying pending bit is present, which is the fourth edge after the input rises. vec_o then carries the index of the winning source.
- R7: While the global enable is 0, irq_o stays 0 and pending bits still collect.
- R8: While irq_o is 1 and no acknowledge is given, vec_o holds its value, even if a higher-level request arrives.
- R9: ack_i asserted while irq_o is 1 clears the pending bit of source vec_o at that edge. irq_o is 0 for the next cycle, and the next winner is presented one edge later. ack_i while irq_o is 0 has no effect.
- R10: Writing 1 to a bit at address 0 clears that pending bit. A new edge on the same source in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Raw request lines, asynchronous |
| bus_addr_i | input | ADDR_W | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| ack_i | input | 1 | Processor acknowledge of the presented vector |
| irq_o | output | 1 | Registered interrupt request to the processor |
| vec_o | output | VEC_W | Index of the presented source |

## Verification
A request input that rises before edge 1 sets its pending bit at edge 3 and raises irq_o at edge 4. The bench changes inputs on falling edges and samples on falling edges. It samples exactly after that fourth edge, and it checks that irq_o is still low one cycle earlier. A read returns data at the edge after the address is presented, so each read samples on the falling edge that follows. After an acknowledge, irq_o is checked low after the next edge and checked for the following winner one edge later. The race between a clear and a new edge is lined up so that the write and the detected edge reach the same rising edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_MED  = 2'b10,
    LVL_HIGH = 2'b11
  } irq_level_e;

  localparam logic [1:0] ADDR_PEND = 2'd0;
  localparam logic [1:0] ADDR_LVLH = 2'd1;
  localparam logic [1:0] ADDR_LVLL = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] raw_i,
  output logic [NUM_SRC-1:0] rise_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic [2:0] shreg;
    always_ff @(posedge clk) begin
      if (rst) shreg <= '0;
      else     shreg <= {shreg[1:0], raw_i[g]};
    end
    assign rise_o[g] = shreg[1] & ~shreg[2];
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int VEC_W   = 2
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] lvl_hi_i,
  input  logic [NUM_SRC-1:0] lvl_lo_i,
  output logic               any_o,
  output logic [VEC_W-1:0]   idx_o
);
  irq_level_e best_lvl;
  irq_level_e cur_lvl;

  always_comb begin
    best_lvl = LVL_OFF;
    cur_lvl  = LVL_OFF;
    idx_o    = '0;
    any_o    = 1'b0;
    // scan from the top index down so an equal level at a lower index replaces
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      cur_lvl = irq_level_e'({lvl_hi_i[i], lvl_lo_i[i]});
      if (pend_i[i] && (cur_lvl != LVL_OFF) && (cur_lvl >= best_lvl)) begin
        best_lvl = cur_lvl;
        idx_o    = VEC_W'(i);
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2,
  localparam int VEC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [NUM_SRC-1:0] src_rise;
  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic [NUM_SRC-1:0] lvl_hi_q, lvl_lo_q;
  logic               gen_en_q;
  logic [NUM_SRC-1:0] clr_mask, ack_mask;
  logic               ack_take;
  logic               arb_any;
  logic [VEC_W-1:0]   arb_idx;
  logic [DATA_W-1:0]  rd_d;
  logic [1:0]         sel;

  assign sel = bus_addr_i[1:0];

  irq_edge_sync #(.NUM_SRC(NUM_SRC)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (src_i),
    .rise_o (src_rise)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) arb_i (
    .pend_i   (pend_q),
    .lvl_hi_i (lvl_hi_q),
    .lvl_lo_i (lvl_lo_q),
    .any_o    (arb_any),
    .idx_o    (arb_idx)
  );

  assign ack_take = ack_i & irq_o;
  assign clr_mask = (bus_we_i && sel == ADDR_PEND) ? bus_wdata_i[NUM_SRC-1:0] : '0;
  assign ack_mask = ack_take ? ({{(NUM_SRC-1){1'b0}}, 1'b1} << vec_o) : '0;
  assign pend_d   = (pend_q & ~clr_mask & ~ack_mask) | src_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      lvl_hi_q <= '0;
      lvl_lo_q <= '0;
      gen_en_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (bus_we_i && sel == ADDR_LVLH) lvl_hi_q <= bus_wdata_i[NUM_SRC-1:0];
      if (bus_we_i && sel == ADDR_LVLL) lvl_lo_q <= bus_wdata_i[NUM_SRC-1:0];
      if (bus_we_i && sel == ADDR_CTRL) gen_en_q <= bus_wdata_i[0];
    end
  end

  always_comb begin
    rd_d = '0;
    case (sel)
      ADDR_PEND: rd_d[NUM_SRC-1:0] = pend_q;
      ADDR_LVLH: rd_d[NUM_SRC-1:0] = lvl_hi_q;
      ADDR_LVLL: rd_d[NUM_SRC-1:0] = lvl_lo_q;
      default:   rd_d[0]           = gen_en_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata_o <= '0;
    else     bus_rdata_o <= rd_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else if (ack_take || !gen_en_q) begin
      irq_o <= 1'b0;
    end else if (!irq_o) begin
      irq_o <= arb_any;
      vec_o <= arb_idx;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NUM_SRC = 4,
  parameter int VEC_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic               ack_i,
  input logic               gen_en_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] src_rise
);
  a_r7_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !gen_en_q |=> !irq_o);

  a_r8_vec_held: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i) |=> $stable(vec_o));

  a_r9_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i) |=> !irq_o);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i && !src_rise[vec_o]) |=> !pend_q[$past(vec_o)]);

  a_r10_edge_sets: assert property (@(posedge clk) disable iff (rst)
    (|src_rise) |=> ((pend_q & $past(src_rise)) == $past(src_rise)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .irq_o    (irq_o),
  .vec_o    (vec_o),
  .ack_i    (ack_i),
  .gen_en_q (gen_en_q),
  .pend_q   (pend_q),
  .src_rise (src_rise)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int NUM_SRC = 4;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int NV      = 8;
  // {src pattern, level-high, level-low, global enable, expected irq, expected vec}
  localparam logic [15:0] VEC_TAB [NV] = '{
    {4'b0001, 4'b0000, 4'b0001, 1'b1, 1'b1, 2'd0},
    {4'b0110, 4'b0110, 4'b0000, 1'b1, 1'b1, 2'd1},
    {4'b1111, 4'b1000, 4'b1010, 1'b1, 1'b1, 2'd3},
    {4'b1111, 4'b0100, 4'b0011, 1'b1, 1'b1, 2'd2},
    {4'b0011, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0},
    {4'b0001, 4'b0001, 4'b0001, 1'b0, 1'b0, 2'd0},
    {4'b1010, 4'b1010, 4'b1010, 1'b1, 1'b1, 2'd1},
    {4'b1001, 4'b0001, 4'b1000, 1'b1, 1'b1, 2'd0}
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_SRC-1:0] src = '0;
  logic [ADDR_W-1:0]  addr = '0;
  logic               we = 1'b0;
  logic [DATA_W-1:0]  wdata = '0;
  logic [DATA_W-1:0]  rdata;
  logic               ack = 1'b0;
  logic               irq;
  logic [1:0]         vec;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk (clk), .rst (rst), .src_i (src), .bus_addr_i (addr), .bus_we_i (we),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata), .ack_i (ack), .irq_o (irq), .vec_o (vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; src = '0; we = 1'b0; ack = 1'b0;
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    wait_n(1);
    we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    addr = a;
    wait_n(1);
    d = rdata;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    wait_n(1);
    ack = 1'b0;
  endtask

  initial begin
    logic [DATA_W-1:0] r;
    wait_n(1);
    do_reset();
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 vec", vec, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], r);
      check("R1 reg", r, 0);
    end

    // Table walk: R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      do_reset();
      wr(2'd1, {4'b0, VEC_TAB[k][11:8]});
      wr(2'd2, {4'b0, VEC_TAB[k][7:4]});
      wr(2'd3, {7'b0, VEC_TAB[k][3]});
      src = VEC_TAB[k][15:12];
      wait_n(4);
      check("R5 table irq", irq, VEC_TAB[k][2]);
      if (VEC_TAB[k][2]) check("R5 table vec", vec, VEC_TAB[k][1:0]);
      src = '0;
    end

    // R3 reserved bits and readback
    do_reset();
    wr(2'd1, 8'hFF);
    rd(2'd1, r);
    check("R3 reserved high bits", r, 8'h0F);
    wr(2'd3, 8'hFE);
    rd(2'd3, r);
    check("R3 ctrl reserved", r, 8'h00);

    // R4 off sources still pend
    do_reset();
    wr(2'd3, 8'h01);
    src = 4'b0011;
    wait_n(5);
    check("R4 off no irq", irq, 0);
    rd(2'd0, r);
    check("R4 off still pends", r, 8'h03);

    // R6 due cycle, R2 held level sets once
    do_reset();
    wr(2'd1, 8'h01);
    wr(2'd3, 8'h01);
    src = 4'b0001;
    wait_n(3);
    check("R6 irq not yet", irq, 0);
    wait_n(1);
    check("R6 irq due", irq, 1);
    check("R6 vec", vec, 0);
    pulse_ack();
    check("R9 irq drop", irq, 0);
    wait_n(4);
    check("R2 held level once irq", irq, 0);
    rd(2'd0, r);
    check("R2 held level once pend", r, 8'h00);
    src = '0;

    // R9 ack sequencing at equal level
    do_reset();
    wr(2'd2, 8'h03);
    wr(2'd3, 8'h01);
    src = 4'b0011;
    wait_n(4);
    check("R9 first vec", vec, 0);
    pulse_ack();
    check("R9 gap", irq, 0);
    wait_n(1);
    check("R9 next irq", irq, 1);
    check("R9 next vec", vec, 1);
    pulse_ack();
    wait_n(2);
    check("R9 all served", irq, 0);
    src = '0;

    // R7 polled mode, R9 ack ignored while idle
    do_reset();
    wr(2'd2, 8'h01);
    src = 4'b0001;
    wait_n(4);
    src = '0;
    check("R7 no irq", irq, 0);
    pulse_ack();
    rd(2'd0, r);
    check("R9 idle ack ignored", r, 8'h01);
    wr(2'd3, 8'h01);
    wait_n(1);
    check("R7 enable delivers", irq, 1);

    // R8 vector held against a later higher request
    do_reset();
    wr(2'd1, 8'h08);
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h01);
    src = 4'b0001;
    wait_n(4);
    check("R8 first vec", vec, 0);
    src = 4'b1001;
    wait_n(5);
    check("R8 vec held", vec, 0);
    check("R8 irq held", irq, 1);
    pulse_ack();
    wait_n(1);
    check("R8 after ack vec", vec, 3);
    src = '0;

    // R10 write-1-clear and race with a new edge
    do_reset();
    src = 4'b0110;
    wait_n(4);
    src = '0;
    wr(2'd0, 8'h02);
    rd(2'd0, r);
    check("R10 clear one bit", r, 8'h04);
    wait_n(3);
    src = 4'b0100;
    wait_n(2);
    wr(2'd0, 8'h04);
    rd(2'd0, r);
    check("R10 edge beats clear", r, 8'h04);
    src = '0;
    wr(2'd0, 8'h04);
    rd(2'd0, r);
    check("R10 plain clear", r, 8'h00);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule